// File: doc/BRIEF.md
# Sample-Rate Phase Accumulator

This block keeps a 48-bit phase accumulator that advances by a programmable frequency word on every clock. Its top bit is the sample clock of a transmit path. The accumulator is split into three output fields. The top bit gives a one-cycle sample strobe that moves user data into the shaping filters. A coarse field of 2, 3 or 4 bits sequences a shaping filter at 4x, 8x or 16x the sample rate. A 16-bit fine field steers an interpolator that resamples to the clock rate. One frequency LSB is the clock frequency divided by 2^48.

Software writes the frequency word as three 16-bit words through a plain one-cycle write strobe:

- Address 4 carries bits 47:32.
- Address 5 carries bits 31:16.
- Address 6 carries bits 15:0.

The first two writes only fill holding registers. The write to address 6 loads the whole word at once. The write port has no ready signal and applies no back-pressure: every strobed write is taken on the edge where it is seen.

A 2-bit quarter-turn offset is added to the output phase and never to the stored count. An external integer counter can pulse two inputs to zero the coarse bits, the bits below them, or both.

Top module: `nco_sample_rate`

## Requirements
- R1: After reset, the accumulator, the frequency word and both holding registers are zero. With no write, every output therefore stays zero.
- R2: A write to address 4 or 5 changes only a holding register. The accumulator keeps stepping by the previously loaded word.
- R3: A write to address 6 loads {addr-4 data, addr-5 data, addr-6 data} as the frequency word. The accumulator first adds the new word on the edge after the write edge.
- R4: With no clear input, the accumulator adds the frequency word on every rising clock edge, modulo 2^48.
- R5: `sample_stb` is high for exactly one cycle after each accumulator edge that takes the un-offset accumulator bit 47 from 0 to 1. It is never high on two consecutive cycles.
- R6: The output phase is the accumulator plus `qtr_off` times 2^46. `coarse_ph` holds the bits just below bit 47 of that phase: 2 bits [46:45] for `rate_sel`=0, 3 bits [46:44] for 1, and 4 bits [46:43] for 2 or 3. It is zero-extended to 4 bits.
- R7: `fine_ph` is the 16 bits of the output phase directly below the coarse field: [44:29], [43:28] or [42:27] for the three coarse widths.
- R8: `phase_msb` is bit 47 of the output phase. `qtr_off` changes only the outputs and never the stored accumulator.
- R9: When `clr_coarse` is high at an edge, the coarse bits selected by `rate_sel` are zero in the new accumulator value. Bit 47 and the lower bits are unaffected.
- R10: When `clr_fine` is high at an edge, every bit below the selected coarse field is zero in the new accumulator value. Both clears may be combined, and neither one touches bit 47.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | One-cycle write strobe for the frequency words |
| cfg_addr | input | 4 | Word address: 4, 5 or 6 |
| cfg_wdata | input | 16 | Frequency word slice |
| rate_sel | input | 2 | Coarse width select: 0 gives 4x, 1 gives 8x, 2 or 3 give 16x |
| qtr_off | input | 2 | Quarter-turn offset added to the output phase |
| clr_coarse | input | 1 | Zero the selected coarse bits at this edge |
| clr_fine | input | 1 | Zero all bits below the coarse field at this edge |
| sample_stb | output | 1 | One-cycle strobe on each rise of accumulator bit 47 |
| phase_msb | output | 1 | Bit 47 of the offset output phase |
| coarse_ph | output | 4 | Coarse filter phase, zero-extended |
| fine_ph | output | 16 | Fine interpolator phase |

## Verification
The clear assertions compare the new accumulator against the clear mask of the cycle before. This allows `rate_sel` to change on any cycle. The bench still changes it only at a falling edge, between runs.

The properties treat `cfg_addr` as meaningful only while `cfg_wr_en` is high, and they place no limit on how close together the writes come.

The bench holds the offset and the rate constant within each sweep run. It drives the clears from a shift-register pattern at about one edge in eight. This keeps the strobe rhythm visible between clears.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int ADDR_W     = 4;
  localparam int COARSE_MAX = 4;

  localparam logic [ADDR_W-1:0] ADR_HI  = 4'h4;
  localparam logic [ADDR_W-1:0] ADR_MID = 4'h5;
  localparam logic [ADDR_W-1:0] ADR_LO  = 4'h6;

  typedef enum logic [1:0] {
    RATE_X4   = 2'd0,
    RATE_X8   = 2'd1,
    RATE_X16  = 2'd2,
    RATE_X16B = 2'd3
  } rate_e;

  // number of coarse phase bits for a rate select
  function automatic int coarse_bits(logic [1:0] r);
    case (r)
      RATE_X4: return 2;
      RATE_X8: return 3;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/nco_freq_regs.sv
module nco_freq_regs
  import nco_pkg::*;
#(
  parameter int WORD_W = 16,
  localparam int ACC_W = 3 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  output logic [ACC_W-1:0]  freq
);
  logic [WORD_W-1:0] hold_hi_q, hold_mid_q;
  logic [ACC_W-1:0]  freq_q;
  logic              commit;

  assign commit = wr_en && (wr_addr == ADR_LO);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_hi_q  <= '0;
      hold_mid_q <= '0;
      freq_q     <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADR_HI)  hold_hi_q  <= wr_data;
      if (wr_addr == ADR_MID) hold_mid_q <= wr_data;
      if (commit)             freq_q     <= {hold_hi_q, hold_mid_q, wr_data};
    end
  end

  assign freq = freq_q;

  // R2: only the low-word write may move the live word
  a_r2_freq_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(freq_q));

  // R3: low slice of the loaded word is the data written with the commit
  a_r3_commit_low: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> freq_q[WORD_W-1:0] == $past(wr_data));
endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc
  import nco_pkg::*;
#(
  parameter int ACC_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] freq,
  input  logic [1:0]       rate_sel,
  input  logic             clr_coarse,
  input  logic             clr_fine,
  output logic [ACC_W-1:0] acc
);
  localparam int TOP = ACC_W - 1;

  logic [ACC_W-1:0] acc_q, sum, acc_d;
  logic [ACC_W-1:0] coarse_mask, low_mask;
  int               cw;

  always_comb begin
    cw = coarse_bits(rate_sel);
    for (int i = 0; i < ACC_W; i++) begin
      low_mask[i]    = (i < TOP - cw);
      coarse_mask[i] = (i >= TOP - cw) && (i < TOP);
    end
  end

  always_comb begin
    sum   = acc_q + freq;
    acc_d = sum;
    if (clr_coarse) acc_d = acc_d & ~coarse_mask;
    if (clr_fine)   acc_d = acc_d & ~low_mask;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign acc = acc_q;

  // R4: plain modular step when no clear is requested
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_coarse && !clr_fine) |=> acc_q == $past(acc_q) + $past(freq));

  // R9: selected coarse bits are empty after a coarse clear
  a_r9_coarse_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_coarse |=> (acc_q & $past(coarse_mask)) == '0);

  // R10: bits below the coarse field are empty after a fine clear
  a_r10_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fine |=> (acc_q & $past(low_mask)) == '0);

  // R10: bit 47 follows the unmasked sum whatever is cleared
  a_r10_top_kept: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> acc_q[TOP] == $past(acc_q[TOP] ^ freq[TOP] ^ carry_top));

  logic carry_top;
  assign carry_top = sum[TOP] ^ acc_q[TOP] ^ freq[TOP];
endmodule

// File: rtl/nco_phase_split.sv
module nco_phase_split
  import nco_pkg::*;
#(
  parameter int ACC_W  = 48,
  parameter int FINE_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [ACC_W-1:0]      acc,
  input  logic [1:0]            qtr_off,
  input  logic [1:0]            rate_sel,
  output logic                  sample_stb,
  output logic                  phase_msb,
  output logic [COARSE_MAX-1:0] coarse_ph,
  output logic [FINE_W-1:0]     fine_ph
);
  localparam int TOP = ACC_W - 1;

  logic [ACC_W-1:0] ph;
  logic             msb_q;

  assign ph        = acc + {qtr_off, {(ACC_W-2){1'b0}}};
  assign phase_msb = ph[TOP];

  always_comb begin
    case (rate_sel)
      RATE_X4: begin
        coarse_ph = {2'b00, ph[TOP-1 -: 2]};
        fine_ph   = ph[TOP-3 -: FINE_W];
      end
      RATE_X8: begin
        coarse_ph = {1'b0, ph[TOP-1 -: 3]};
        fine_ph   = ph[TOP-4 -: FINE_W];
      end
      default: begin
        coarse_ph = ph[TOP-1 -: 4];
        fine_ph   = ph[TOP-5 -: FINE_W];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) msb_q <= 1'b0;
    else        msb_q <= acc[TOP];
  end

  assign sample_stb = acc[TOP] & ~msb_q;

  // R5: the strobe never lasts two cycles
  a_r5_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
    sample_stb |=> !sample_stb);

  // R6: narrow coarse modes leave the spare bits at zero
  a_r6_coarse_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_sel == RATE_X4) |-> coarse_ph[3:2] == 2'b00);
endmodule

// File: rtl/nco_sample_rate.sv
module nco_sample_rate
  import nco_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int FINE_W = 16,
  localparam int ACC_W = 3 * WORD_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_wr_en,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [WORD_W-1:0]     cfg_wdata,
  input  logic [1:0]            rate_sel,
  input  logic [1:0]            qtr_off,
  input  logic                  clr_coarse,
  input  logic                  clr_fine,
  output logic                  sample_stb,
  output logic                  phase_msb,
  output logic [COARSE_MAX-1:0] coarse_ph,
  output logic [FINE_W-1:0]     fine_ph
);
  logic [ACC_W-1:0] freq, acc;

  nco_freq_regs #(.WORD_W(WORD_W)) freq_i (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_addr(cfg_addr),
    .wr_data(cfg_wdata), .freq(freq)
  );

  nco_phase_acc #(.ACC_W(ACC_W)) acc_i (
    .clk(clk), .rst_n(rst_n), .freq(freq), .rate_sel(rate_sel),
    .clr_coarse(clr_coarse), .clr_fine(clr_fine), .acc(acc)
  );

  nco_phase_split #(.ACC_W(ACC_W), .FINE_W(FINE_W)) split_i (
    .clk(clk), .rst_n(rst_n), .acc(acc), .qtr_off(qtr_off),
    .rate_sel(rate_sel), .sample_stb(sample_stb), .phase_msb(phase_msb),
    .coarse_ph(coarse_ph), .fine_ph(fine_ph)
  );

  // R8: the offset must not reach the stored count
  a_r8_offset_free: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_coarse && !clr_fine && !$stable(qtr_off)) |=>
      acc == $past(acc) + $past(freq));
endmodule

// File: tb/nco_sample_rate_tb.sv
module nco_sample_rate_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [1:0]  rate_sel = '0;
  logic [1:0]  qtr_off = '0;
  logic        clr_coarse = 1'b0;
  logic        clr_fine = 1'b0;
  logic        sample_stb, phase_msb;
  logic [3:0]  coarse_ph;
  logic [15:0] fine_ph;

  nco_sample_rate dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .rate_sel(rate_sel), .qtr_off(qtr_off),
    .clr_coarse(clr_coarse), .clr_fine(clr_fine), .sample_stb(sample_stb),
    .phase_msb(phase_msb), .coarse_ph(coarse_ph), .fine_ph(fine_ph)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [47:0] acc_m = '0, freq_m = '0;
  logic [15:0] hi_m = '0, mid_m = '0;
  logic        prev_m = 1'b0;
  logic        last_cc = 1'b0, last_cf = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  string       ctx = "";

  function automatic int cwid(logic [1:0] r);
    return (r == 2'd0) ? 2 : (r == 2'd1) ? 3 : 4;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, ctx, act, exp);
    end
  endtask

  task automatic model_edge();
    int cw;
    logic [47:0] s, cm, lm;
    cw = cwid(rate_sel);
    s  = acc_m + freq_m;
    cm = ((48'd1 << cw) - 48'd1) << (47 - cw);
    lm = (48'd1 << (47 - cw)) - 48'd1;
    if (clr_coarse) s = s & ~cm;
    if (clr_fine)   s = s & ~lm;
    last_cc = clr_coarse;
    last_cf = clr_fine;
    prev_m  = acc_m[47];
    acc_m   = s;
    if (cfg_wr_en) begin
      if (cfg_addr == 4'h4) hi_m  = cfg_wdata;
      if (cfg_addr == 4'h5) mid_m = cfg_wdata;
      if (cfg_addr == 4'h6) freq_m = {hi_m, mid_m, cfg_wdata};
    end
  endtask

  task automatic check_all();
    int cw;
    logic [47:0] ph;
    cw = cwid(rate_sel);
    ph = acc_m + {qtr_off, 46'd0};
    check("R5", {63'd0, sample_stb}, {63'd0, acc_m[47] & ~prev_m});
    check("R8", {63'd0, phase_msb}, {63'd0, ph[47]});
    check(last_cc ? "R9" : "R6", {60'd0, coarse_ph},
          {16'd0, (ph >> (47 - cw)) & ((48'd1 << cw) - 48'd1)});
    check(last_cf ? "R10" : "R7", {48'd0, fine_ph},
          {16'd0, (ph >> (31 - cw)) & 48'hFFFF});
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_all();
  endtask

  task automatic write(logic [3:0] a, logic [15:0] d);
    cfg_wr_en = 1'b1; cfg_addr = a; cfg_wdata = d;
    step();
    cfg_wr_en = 1'b0;
  endtask

  task automatic load(logic [47:0] f);
    write(4'h4, f[47:32]);
    write(4'h5, f[31:16]);
    write(4'h6, f[15:0]);
  endtask

  initial begin
    logic [47:0] words [3];
    words[0] = 48'h0C00_0000_0001;
    words[1] = 48'h3123_4567_89AB;
    words[2] = 48'hF000_0000_0005;

    // R1: reset state
    repeat (3) @(negedge clk);
    ctx = "R1 in reset";
    check("R1", {60'd0, coarse_ph}, 64'd0);
    check("R1", {48'd0, fine_ph}, 64'd0);
    check("R1", {62'd0, sample_stb, phase_msb}, 64'd0);
    rst_n = 1'b1;
    ctx = "R1 idle";
    repeat (4) step();

    // R2: staged words leave the stepping untouched
    ctx = "R2 staged";
    write(4'h4, 16'h0C00);
    write(4'h5, 16'h0000);
    repeat (3) step();
    check("R2", {48'd0, fine_ph}, 64'd0);

    // R3: commit then step by the new word
    ctx = "R3 commit";
    write(4'h6, 16'h0001);
    repeat (30) step();

    // R2: restage during stepping, word stays old until commit
    ctx = "R2 restage";
    write(4'h4, 16'h7FFF);
    write(4'h5, 16'hFFFF);
    repeat (20) step();
    ctx = "R3 second commit";
    write(4'h6, 16'hFFFF);
    repeat (10) step();

    // R4..R10: sweep words x rates x offsets with clear pulses
    for (int w = 0; w < 3; w++) begin
      load(words[w]);
      for (int r = 0; r < 4; r++) begin
        for (int o = 0; o < 4; o++) begin
          rate_sel = r[1:0];
          qtr_off  = o[1:0];
          ctx = $sformatf("R4 sweep w%0d r%0d o%0d", w, r, o);
          for (int c = 0; c < 40; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            clr_coarse = (lfsr[2:0] == 3'b101);
            clr_fine   = (lfsr[6:4] == 3'b011);
            step();
          end
          clr_coarse = 1'b0;
          clr_fine   = 1'b0;
        end
      end
    end

    // R8: offset switching does not move the stored count
    ctx = "R8 offset toggle";
    for (int k = 0; k < 16; k++) begin
      qtr_off = k[1:0];
      step();
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule